// File: doc/BRIEF.md
# Dual-Enable Half-Word-Masked Static Memory

This block models a 32-bit-wide static memory with word-parallel access and a 17-bit address in its full configuration (131,072 words). Selection takes two chip selects of opposite polarity: an active-low select and an active-high select. Both must be asserted for the memory to respond. An active-low write strobe selects writes. An active-low output enable gates read data. Two active-low half-word enables each own one 16-bit half. The low enable owns bits 15:0 and the high enable owns bits 31:16. Each enable masks the write to its half and also decides whether that half is driven on a read.

The bidirectional data bus is split into a write-data input, a read-data output and a two-bit drive vector. Each drive bit stands in for the output enable of one half, so no tristate nets are needed. The array is a register array. Writes take effect on the rising edge of `clk_i`, and reads are combinational from the current contents, which keeps the asynchronous feel of the memory while a synchronous bench can still drive it. The address width is a parameter. Its default is small so that elaboration stays light, and the full part uses `ADDR_W = 17`.

Top module: `dual_en_sram`

## Requirements
- R1: The memory is selected only when `cs_ni` is 0 and `cs_i` is 1. While it is not selected, `drv_o` is 2'b00, `dout_o` is 0, and no location is written.
- R2: A write is performed when the memory is selected and `we_ni` is 0, whatever the value of `oe_ni`.
- R3: A read drives data only when the memory is selected, `oe_ni` is 0 and `we_ni` is 1. Each enabled half then carries the addressed word's contents.
- R4: `lo_en_ni` (active low) owns bits 15:0 and `drv_o[0]`. `hi_en_ni` (active low) owns bits 31:16 and `drv_o[1]`.
- R5: When exactly one half-word enable is 1, that half is neither written nor driven, while the other half works normally.
- R6: When both half-word enables are 1, no write takes place and `drv_o` is 2'b00.
- R7: `drv_o` is 2'b00 whenever `oe_ni` is 1 or a write is in progress.
- R8: Any half whose `drv_o` bit is 0 shows 16'h0000 on `dout_o`.
- R9: A half-word write changes only the enabled half of the addressed word. The other half keeps its earlier contents.
- R10: While `rst_ni` is 0, every location is cleared to zero, so reads after reset return 0.
- R11: A write becomes visible on the rising edge of `clk_i` that samples it. A read in the following cycle returns the new data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Evaluation clock; the array updates on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset; clears the array |
| cs_ni | input | 1 | Chip select, active low |
| cs_i | input | 1 | Chip select, active high |
| we_ni | input | 1 | Write strobe, active low |
| oe_ni | input | 1 | Output enable, active low |
| lo_en_ni | input | 1 | Enable for bits 15:0, active low |
| hi_en_ni | input | 1 | Enable for bits 31:16, active low |
| addr_i | input | ADDR_W | Word address |
| din_i | input | 32 | Write data |
| dout_o | output | 32 | Read data, zero in undriven halves |
| drv_o | output | 2 | Per-half drive flag (bit 0 low half, bit 1 high half) |

## Verification
The assertions check on every cycle that the drive flags appear only under a qualified read, which covers the selects, the output enable and the write strobe. They also check that each drive flag follows its own half-word enable and that undriven halves read as zero. A further assertion checks that a written half reads back its data one cycle later at the same address. Only the bench's scenarios can show that a masked half keeps its old contents, because that needs a history of several writes to the same word. The same holds for writes blocked by deselect or by both enables, which leave the array unchanged, and for the array reading as zero after reset. The bench confirms these by comparing against a behavioural model on every clock.

// File: rtl/sram_pkg.sv
package sram_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned N_HALF = 2;
  localparam int unsigned HALF_W = DATA_W / N_HALF;

  typedef struct packed {
    logic sel;
    logic wr;
    logic rd;
  } sram_ctl_t;
endpackage

// File: rtl/sram_decode.sv
module sram_decode
  import sram_pkg::*;
(
  input  logic              cs_ni,
  input  logic              cs_i,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic [N_HALF-1:0] half_en_ni,
  output sram_ctl_t         ctl_o,
  output logic [N_HALF-1:0] half_wr_o,
  output logic [N_HALF-1:0] half_drv_o
);
  sram_ctl_t ctl;

  always_comb begin
    ctl.sel = ~cs_ni & cs_i;
    // write strobe wins over output enable
    ctl.wr  = ctl.sel & ~we_ni;
    ctl.rd  = ctl.sel & we_ni & ~oe_ni;
  end

  for (genvar h = 0; h < N_HALF; h++) begin : g_half
    assign half_wr_o[h]  = ctl.wr & ~half_en_ni[h];
    assign half_drv_o[h] = ctl.rd & ~half_en_ni[h];
  end

  assign ctl_o = ctl;
endmodule

// File: rtl/sram_half_bank.sv
module sram_half_bank #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned W      = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [W-1:0]      wdata_i,
  input  logic              drv_i,
  output logic [W-1:0]      rdata_o
);
  localparam int unsigned DEPTH = 2 ** ADDR_W;

  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (wr_i) begin
      mem_q[addr_i] <= wdata_i;
    end
  end

  // undriven half reads as zero for deterministic checking
  assign rdata_o = drv_i ? mem_q[addr_i] : '0;
endmodule

// File: rtl/dual_en_sram.sv
module dual_en_sram
  import sram_pkg::*;
#(
  parameter int unsigned ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              cs_i,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic              lo_en_ni,
  input  logic              hi_en_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       din_i,
  output logic [31:0]       dout_o,
  output logic [1:0]        drv_o
);
  sram_ctl_t         ctl;
  logic [N_HALF-1:0] half_wr;
  logic [N_HALF-1:0] half_drv;

  sram_decode u_dec (
    .cs_ni      (cs_ni),
    .cs_i       (cs_i),
    .we_ni      (we_ni),
    .oe_ni      (oe_ni),
    .half_en_ni ({hi_en_ni, lo_en_ni}),
    .ctl_o      (ctl),
    .half_wr_o  (half_wr),
    .half_drv_o (half_drv)
  );

  for (genvar h = 0; h < N_HALF; h++) begin : g_bank
    sram_half_bank #(
      .ADDR_W (ADDR_W),
      .W      (HALF_W)
    ) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .addr_i  (addr_i),
      .wr_i    (half_wr[h]),
      .wdata_i (din_i[h*HALF_W +: HALF_W]),
      .drv_i   (half_drv[h]),
      .rdata_o (dout_o[h*HALF_W +: HALF_W])
    );
  end

  assign drv_o = half_drv;

  logic unused_ctl;
  assign unused_ctl = ^ctl;
endmodule

// File: rtl/dual_en_sram_chk.sv
module dual_en_sram_chk #(
  parameter int unsigned ADDR_W = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_ni,
  input logic              cs_i,
  input logic              we_ni,
  input logic              oe_ni,
  input logic              lo_en_ni,
  input logic              hi_en_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       din_i,
  input logic [31:0]       dout_o,
  input logic [1:0]        drv_o
);
  logic sel_w, wr_lo_w, rd_lo_w;
  assign sel_w   = ~cs_ni & cs_i;
  assign wr_lo_w = sel_w & ~we_ni & ~lo_en_ni;
  assign rd_lo_w = sel_w & we_ni & ~oe_ni & ~lo_en_ni;

  // R1
  deselect_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_w |-> (drv_o == 2'b00 && dout_o == 32'h0));

  // R7
  no_drive_unqualified_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_ni || !we_ni) |-> drv_o == 2'b00);

  // R4
  drive_follows_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drv_o[0] |-> !lo_en_ni) and (drv_o[1] |-> !hi_en_ni));

  // R6
  both_off_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lo_en_ni && hi_en_ni) |-> drv_o == 2'b00);

  // R8
  undriven_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!drv_o[0] |-> dout_o[15:0] == 16'h0) and (!drv_o[1] |-> dout_o[31:16] == 16'h0));

  // R11
  write_readback_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(wr_lo_w) && rd_lo_w && addr_i == $past(addr_i))
      |-> dout_o[15:0] == $past(din_i[15:0]));
endmodule

bind dual_en_sram dual_en_sram_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cs_ni    (cs_ni),
  .cs_i     (cs_i),
  .we_ni    (we_ni),
  .oe_ni    (oe_ni),
  .lo_en_ni (lo_en_ni),
  .hi_en_ni (hi_en_ni),
  .addr_i   (addr_i),
  .din_i    (din_i),
  .dout_o   (dout_o),
  .drv_o    (drv_o)
);

// File: tb/dual_en_sram_tb.sv
module dual_en_sram_tb;
  localparam int unsigned ADDR_W = 10;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              cs_ni = 1'b1, cs_i = 1'b0, we_ni = 1'b1, oe_ni = 1'b1;
  logic              lo_en_ni = 1'b1, hi_en_ni = 1'b1;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [31:0]       din_i = '0;
  logic [31:0]       dout_o;
  logic [1:0]        drv_o;

  int n_vec = 0;
  int n_bad = 0;
  logic [31:0] mdl [int];

  always #2 clk_i = ~clk_i;

  dual_en_sram #(.ADDR_W(ADDR_W)) u_dut (.*);

  function automatic logic [31:0] rd_mdl(int a);
    return mdl.exists(a) ? mdl[a] : 32'h0;
  endfunction

  task automatic check(string tag, logic [31:0] exp_d, logic [1:0] exp_v);
    n_vec++;
    if (dout_o !== exp_d || drv_o !== exp_v) begin
      n_bad++;
      $display("FAIL %s: dout=%h drv=%b expected dout=%h drv=%b", tag, dout_o, drv_o, exp_d, exp_v);
    end
  endtask

  task automatic step(string tag, logic csn, logic cs, logic wen, logic oen,
                      logic lon, logic hin, int a, logic [31:0] d);
    logic sel, wr, rd;
    logic [1:0]  ev;
    logic [31:0] ed, cur;
    @(negedge clk_i);
    cs_ni = csn; cs_i = cs; we_ni = wen; oe_ni = oen;
    lo_en_ni = lon; hi_en_ni = hin; addr_i = a[ADDR_W-1:0]; din_i = d;
    sel = !csn && cs;
    wr  = sel && !wen;
    rd  = sel && wen && !oen;
    ev  = rd ? {!hin, !lon} : 2'b00;
    cur = rd_mdl(a);
    ed  = {ev[1] ? cur[31:16] : 16'h0, ev[0] ? cur[15:0] : 16'h0};
    #1 check(tag, ed, ev);
    @(posedge clk_i);
    if (wr) begin
      if (!lon) cur[15:0]  = d[15:0];
      if (!hin) cur[31:16] = d[31:16];
      if (!lon || !hin) mdl[a] = cur;
    end
  endtask

  task automatic wr(string tag, int a, logic [31:0] d, logic lon, logic hin, logic oen);
    step(tag, 1'b0, 1'b1, 1'b0, oen, lon, hin, a, d);
  endtask

  task automatic rd(string tag, int a, logic lon, logic hin);
    step(tag, 1'b0, 1'b1, 1'b1, 1'b0, lon, hin, a, 32'hDEAD_BEEF);
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #1 check("R1", 32'h0, 2'b00);
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;
    // R10 reset contents
    rd("R10", 0, 1'b0, 1'b0);
    rd("R10", 777, 1'b0, 1'b0);
    // R2 R11 write, oe low ignored, immediate readback
    wr("R2", 5, 32'h1234_5678, 1'b0, 1'b0, 1'b0);
    rd("R11", 5, 1'b0, 1'b0);
    wr("R7", 6, 32'hA5A5_5A5A, 1'b0, 1'b0, 1'b1);
    rd("R3", 6, 1'b0, 1'b0);
    // R4 half reads
    rd("R4", 5, 1'b0, 1'b1);
    rd("R4", 5, 1'b1, 1'b0);
    // R9 R5 masked writes keep other half
    wr("R9", 5, 32'hFFFF_0000, 1'b1, 1'b0, 1'b1);
    rd("R9", 5, 1'b0, 1'b0);
    wr("R5", 6, 32'h0000_BEEF, 1'b0, 1'b1, 1'b1);
    rd("R5", 6, 1'b0, 1'b0);
    // R6 both halves off
    wr("R6", 5, 32'h0BAD_0BAD, 1'b1, 1'b1, 1'b1);
    rd("R6", 5, 1'b1, 1'b1);
    rd("R6", 5, 1'b0, 1'b0);
    // R1 deselected writes ignored
    step("R1", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 6, 32'h1111_1111);
    step("R1", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 6, 32'h2222_2222);
    step("R1", 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 6, 32'h0);
    rd("R1", 6, 1'b0, 1'b0);
    // R7 oe high read, R8 zeroed half
    step("R7", 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 6, 32'h0);
    rd("R8", 6, 1'b1, 1'b0);
    wr("R11", 1023, 32'hCAFE_F00D, 1'b0, 1'b0, 1'b1);
    rd("R11", 1023, 1'b0, 1'b0);
    // mixed traffic on a few addresses
    for (int i = 0; i < 2000; i++) begin
      logic [6:0] c;
      c = 7'($urandom);
      step("R3", c[0] & c[1], ~(c[2] & c[3]), c[4], c[5], c[6] & c[0],
           c[6] & c[1], int'($urandom_range(0, 7)) * 129, $urandom);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule